// File: doc/BRIEF.md
# Embedded-Sync Video Stream Decoder

This block takes a single byte-wide stream of interleaved 4:2:2 video in which the line and field timing is carried in-band. No separate sync wires exist. Each timing marker is a four-byte group: an all-ones byte, two all-zero bytes, and a flag byte. The decoder watches for these groups and turns the flag byte into three registered level outputs: horizontal blanking, vertical blanking and the field indicator.

Between a start-of-active marker on a non-blanked line and the next all-ones byte, every incoming byte is a video sample. Each one is routed to a chroma-blue, luma or chroma-red output and flagged with a one-cycle valid strobe and a two-bit lane code. The stream is taken as error-free, so the flag byte's protection bits are ignored. The block sits directly behind the capture flop of a 27 MHz video input, and downstream logic consumes the separated components.

Top module: `embsync_dec`

## Requirements
- R1: While `rstN` is low, `validOut` is 0, `hBlank` is 1, `vBlank` is 1 and `fieldOut` is 0.
- R2: After the byte sequence all-ones, zero, zero, flag byte, the outputs in the cycle after the flag byte is sampled are as follows: `fieldOut` equals flag bit 6, `vBlank` equals flag bit 5 and `hBlank` equals flag bit 4. For the flag byte, bit 4 = 0 means start of active video and bit 4 = 1 means end of active video.
- R3: `hBlank`, `vBlank` and `fieldOut` change only on a decoded flag byte. Blanking bytes and an incomplete preamble (all-ones, zero, then a non-zero byte) leave them unchanged.
- R4: After a start-of-active flag byte with bit 5 = 0, each following byte that is not all-ones is presented one cycle after it is sampled, with `validOut` = 1.
- R5: Samples in a run carry `laneOut` codes 0, 1, 2, 3, 0, … starting from 0 after every start-of-active flag byte. Code 0 = Cb on `cbOut`, codes 1 and 3 = Y on `yOut`, code 2 = Cr on `crOut`.
- R6: A start-of-active flag byte with bit 5 = 1 (vertical blanking line) produces no valid samples.
- R7: An all-ones byte ends a run. `validOut` is 0 for that byte and stays 0 until the next start-of-active flag byte.
- R8: Before the first complete timing marker after reset, `validOut` stays 0 whatever bytes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; bytes captured on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | DW | Combined timing and video byte stream |
| cbOut | output | DW | Last Cb sample |
| yOut | output | DW | Last Y sample |
| crOut | output | DW | Last Cr sample |
| validOut | output | 1 | High for one cycle per presented sample |
| laneOut | output | 2 | Position of the presented sample in the Cb/Y/Cr/Y rotation |
| hBlank | output | 1 | Recovered horizontal blanking |
| vBlank | output | 1 | Recovered vertical blanking |
| fieldOut | output | 1 | Recovered field indicator |

## Verification
Two things can happen on the same byte. The all-ones byte that opens an end marker must both stop an active run and start preamble tracking. A start-of-active flag byte must both restart the lane rotation and arm the run, even when the previous run stopped partway through a Cb/Y/Cr/Y group. The bench sweeps run lengths from zero to nine samples, including lengths that are not a multiple of four, against both field values and both vertical states. It places each end marker directly after the last sample. It then judges that the all-ones byte never shows a valid strobe and that the first sample of the next run is always lane 0 on `cbOut`.

// File: rtl/embsync_pkg.sv
package embsync_pkg;

  typedef enum logic [1:0] {
    SEEK   = 2'd0,
    SAW_FF = 2'd1,
    SAW_Z1 = 2'd2,
    SAW_Z2 = 2'd3
  } seekState_t;

  typedef enum logic [1:0] {
    LANE_CB = 2'd0,
    LANE_Y0 = 2'd1,
    LANE_CR = 2'd2,
    LANE_Y1 = 2'd3
  } lane_t;

  typedef struct packed {
    logic emit;
    logic laneRestart;
  } ctlStrobe_t;

endpackage

// File: rtl/embsync_ctrl.sv
module embsync_ctrl
  import embsync_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] dataIn,
  output ctlStrobe_t    strobe,
  output logic          hBlank,
  output logic          vBlank,
  output logic          fieldOut
);

  localparam int FPos = DW - 2;
  localparam int VPos = DW - 3;
  localparam int HPos = DW - 4;

  seekState_t seekQ, seekD;
  logic isOnes, isZero, isXy, runQ;

  assign isOnes = (dataIn == {DW{1'b1}});
  assign isZero = (dataIn == {DW{1'b0}});
  assign isXy   = (seekQ == SAW_Z2);

  always_comb begin
    seekD = SEEK;
    unique case (seekQ)
      SEEK:    seekD = isOnes ? SAW_FF : SEEK;
      SAW_FF:  seekD = isZero ? SAW_Z1 : (isOnes ? SAW_FF : SEEK);
      SAW_Z1:  seekD = isZero ? SAW_Z2 : (isOnes ? SAW_FF : SEEK);
      SAW_Z2:  seekD = SEEK;
      default: seekD = SEEK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seekQ    <= SEEK;
      runQ     <= 1'b0;
      hBlank   <= 1'b1;
      vBlank   <= 1'b1;
      fieldOut <= 1'b0;
    end else begin
      seekQ <= seekD;
      if (isXy) begin
        runQ     <= !dataIn[HPos] && !dataIn[VPos];
        hBlank   <= dataIn[HPos];
        vBlank   <= dataIn[VPos];
        fieldOut <= dataIn[FPos];
      end else if (isOnes) begin
        runQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.emit        = runQ && !isOnes && !isXy;
    strobe.laneRestart = isXy;
  end

endmodule

// File: rtl/embsync_dp.sv
module embsync_dp
  import embsync_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] dataIn,
  input  ctlStrobe_t    strobe,
  output logic [DW-1:0] cbOut,
  output logic [DW-1:0] yOut,
  output logic [DW-1:0] crOut,
  output logic          validOut,
  output logic [1:0]    laneOut
);

  lane_t laneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      laneQ    <= LANE_CB;
      validOut <= 1'b0;
      laneOut  <= 2'd0;
      cbOut    <= '0;
      yOut     <= '0;
      crOut    <= '0;
    end else begin
      validOut <= strobe.emit;
      if (strobe.laneRestart) begin
        laneQ <= LANE_CB;
      end else if (strobe.emit) begin
        laneQ <= lane_t'(laneQ + 2'd1);
      end
      if (strobe.emit) begin
        laneOut <= laneQ;
        unique case (laneQ)
          LANE_CB:          cbOut <= dataIn;
          LANE_CR:          crOut <= dataIn;
          LANE_Y0, LANE_Y1: yOut  <= dataIn;
          default:          yOut  <= dataIn;
        endcase
      end
    end
  end

endmodule

// File: rtl/embsync_dec.sv
module embsync_dec
  import embsync_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] dataIn,
  output logic [DW-1:0] cbOut,
  output logic [DW-1:0] yOut,
  output logic [DW-1:0] crOut,
  output logic          validOut,
  output logic [1:0]    laneOut,
  output logic          hBlank,
  output logic          vBlank,
  output logic          fieldOut
);

  ctlStrobe_t strobe;

  embsync_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .strobe(strobe),
    .hBlank(hBlank), .vBlank(vBlank), .fieldOut(fieldOut)
  );

  embsync_dp #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .strobe(strobe),
    .cbOut(cbOut), .yOut(yOut), .crOut(crOut),
    .validOut(validOut), .laneOut(laneOut)
  );

endmodule

// File: rtl/embsync_chk.sv
module embsync_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic [DW-1:0] dataIn,
  input logic          validOut,
  input logic [1:0]    laneOut,
  input logic          hBlank,
  input logic          vBlank,
  input logic          fieldOut
);

  logic [DW-1:0] h1, h2, h3, h4;
  logic trsPrev, seenAny;

  assign trsPrev = (h4 == {DW{1'b1}}) && (h3 == '0) && (h2 == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      h1 <= '0; h2 <= '0; h3 <= '0; h4 <= '0;
      seenAny <= 1'b0;
    end else begin
      h1 <= dataIn; h2 <= h1; h3 <= h2; h4 <= h3;
      if (trsPrev) seenAny <= 1'b1;
    end
  end

  p_trs_update_r2: assert property (@(posedge clk) disable iff (!rstN)
    trsPrev |-> (hBlank == h1[DW-4]) && (vBlank == h1[DW-3]) && (fieldOut == h1[DW-2]));

  p_flags_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !trsPrev |-> $stable(hBlank) && $stable(vBlank) && $stable(fieldOut));

  p_lane_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && !$past(validOut)) |-> (laneOut == 2'd0));

  p_lane_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && $past(validOut)) |-> (laneOut == 2'($past(laneOut) + 2'd1)));

  p_valid_in_active_r6: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> (!hBlank && !vBlank));

  p_no_valid_on_ff_r7: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> (h1 != {DW{1'b1}}));

  p_quiet_before_lock_r8: assert property (@(posedge clk) disable iff (!rstN)
    !seenAny |-> !validOut);

endmodule

bind embsync_dec embsync_chk #(.DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .dataIn(dataIn), .validOut(validOut),
  .laneOut(laneOut), .hBlank(hBlank), .vBlank(vBlank), .fieldOut(fieldOut)
);

// File: tb/sim_embsync_dec.sv
`timescale 1ns/1ps
module sim_embsync_dec;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] cbOut, yOut, crOut;
  logic       validOut, hBlank, vBlank, fieldOut;
  logic [1:0] laneOut;

  int checks = 0;
  int errors = 0;
  int lineNo = 0;

  always #5 clk = ~clk;

  embsync_dec #(.DW(8)) u0 (
    .clk(clk), .rstN(rstN), .dataIn(dataIn),
    .cbOut(cbOut), .yOut(yOut), .crOut(crOut),
    .validOut(validOut), .laneOut(laneOut),
    .hBlank(hBlank), .vBlank(vBlank), .fieldOut(fieldOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] b);
    dataIn = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkFlags(input bit h, input bit v, input bit f, input string req);
    check(hBlank == h, req, hBlank, h);
    check(vBlank == v, req, vBlank, v);
    check(fieldOut == f, req, fieldOut, f);
  endtask

  task automatic sendLine(input bit f, input bit v, input int n);
    // end marker; the all-ones byte must never be valid (R7)
    drive(8'hFF);
    check(validOut == 1'b0, "R7", validOut, 0);
    drive(8'h00);
    drive(8'h00);
    drive({1'b1, f, v, 1'b1, 4'h0});
    checkFlags(1'b1, v, f, "R2");
    // blanking and an incomplete preamble leave flags alone (R3)
    drive(8'h80); drive(8'h10);
    drive(8'hFF); drive(8'h00); drive(8'h55);
    checkFlags(1'b1, v, f, "R3");
    check(validOut == 1'b0, "R7", validOut, 0);
    // start marker
    drive(8'hFF); drive(8'h00); drive(8'h00);
    drive({1'b1, f, v, 1'b0, 4'h0});
    checkFlags(1'b0, v, f, "R2");
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'(8'h10 + ((i * 37 + lineNo * 11) % 8'hD0));
      drive(b);
      if (v) begin
        check(validOut == 1'b0, "R6", validOut, 0);
      end else begin
        check(validOut == 1'b1, "R4", validOut, 1);
        check(laneOut == 2'(i % 4), "R5", laneOut, i % 4);
        case (i % 4)
          0:       check(cbOut == b, "R5", cbOut, b);
          2:       check(crOut == b, "R5", crOut, b);
          default: check(yOut == b, "R5", yOut, b);
        endcase
      end
    end
    lineNo++;
  endtask

  initial begin
    int runLens[8] = '{0, 1, 2, 3, 4, 5, 7, 9};
    repeat (3) @(negedge clk);
    // R1: reset values
    check(validOut == 1'b0, "R1", validOut, 0);
    checkFlags(1'b1, 1'b1, 1'b0, "R1");
    rstN = 1'b1;
    // R8: video-like bytes before any marker
    for (int i = 0; i < 8; i++) begin
      drive(8'(8'h40 + i * 8));
      check(validOut == 1'b0, "R8", validOut, 0);
    end
    drive(8'h80);
    check(validOut == 1'b0, "R8", validOut, 0);
    checkFlags(1'b1, 1'b1, 1'b0, "R8");
    for (int fi = 0; fi < 2; fi++)
      for (int vi = 0; vi < 2; vi++)
        foreach (runLens[k]) sendLine(fi[0], vi[0], runLens[k]);
    // field toggling across consecutive lines
    sendLine(1'b0, 1'b0, 6);
    sendLine(1'b1, 1'b0, 6);
    sendLine(1'b0, 1'b0, 3);
    drive(8'hFF);
    check(validOut == 1'b0, "R7", validOut, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule